// File: doc/BRIEF.md
# Flash Byte Program Sequencer with Status Polling

This block is the host-side engine that stores one byte into a parallel NOR flash and then waits until the device reports that the write is finished. A client hands it a target address, a data byte and a polling mode on a valid/ready handshake. The block drives three command write cycles and then the byte write itself on the flash pins. Every write cycle keeps to setup, pulse and hold counts that are derived from nanosecond parameters and the clock period. After the four writes it reads the target address over and over until the device's status bits show completion.

Two completion methods are available. In data-poll mode the block waits until bit 7 of the read value equals bit 7 of the written byte, and then performs one more read to compare the whole byte. In toggle mode it watches bit 6 across consecutive reads and stops when that bit holds its value. A budget of status reads, derived from the worst-case programming time, bounds the wait. When the budget runs out the block reports a timeout and leaves the bus idle.

Top module: `flash_byte_prog`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the next cycle up to and including the cycle in which `done` is high.
- R2: Each request produces exactly four write pulses, in this order: (UNLK_A0, UNLK_D0), (UNLK_A1, UNLK_D1), (CMD_A, CMD_D), then (request address, request data).
- R3: `fl_we_n` stays low for exactly WP_CYC = ceil(T_WP_NS/CLK_NS) cycles. Address and data are driven and stable for at least SET_CYC = max(ceil(T_DS_NS/CLK_NS), ceil(T_AS_NS/CLK_NS), 1) cycles before the falling edge and for the whole pulse. They remain for at least HOLD_CYC = max(ceil(T_AH_NS/CLK_NS), ceil(T_WPH_NS/CLK_NS)) cycles from the rising edge. `fl_we_n` stays high for at least HOLD_CYC+SET_CYC cycles between the pulses of one request.
- R4: While `fl_we_n` is low, `fl_oe_n` is high and `fl_ce_n` is low.
- R5: Every status read holds `fl_oe_n` and `fl_ce_n` low for exactly RD_CYC = ceil(T_RD_NS/CLK_NS) cycles with `fl_addr` equal to the request address. `fl_dq_oe` is low whenever `fl_oe_n` is low. The value is sampled in the last cycle of the read.
- R6: With `req_mode` = 0 (data poll), polling completes on the first read whose bit 7 equals bit 7 of the written byte. Exactly one further verify read follows.
- R7: In data-poll mode, `res_verify_err` is 1 at `done` when the verify read differs from the written byte in any bit, and 0 otherwise.
- R8: With `req_mode` = 1 (toggle), polling completes on the first read whose bit 6 equals bit 6 of the previous read of the same request. No verify read follows, and `res_verify_err` is 0.
- R9: When POLL_LIMIT = max(2, ceil(PROG_MAX_NS/((RD_CYC+GAP_CYC)*CLK_NS))) status reads have passed without completion, `done` rises with `res_timeout` = 1 and `res_verify_err` = 0. At most POLL_LIMIT status reads are made. GAP_CYC = ceil(T_RGAP_NS/CLK_NS) is the number of idle cycles between reads.
- R10: `done` is high for exactly one cycle, and the result flags are valid in that cycle. `req_ready` is high in the cycle after it.
- R11: During and right after reset, `req_ready` = 1 and `done` = 0, and the bus is idle: `fl_ce_n`, `fl_oe_n` and `fl_we_n` are high and `fl_dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Program request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | AW | Byte address to program |
| req_data | input | 8 | Byte to program |
| req_mode | input | 1 | 0: bit-7 data poll, 1: bit-6 toggle poll |
| done | output | 1 | One-cycle completion strobe |
| res_timeout | output | 1 | Poll budget exhausted (valid with done) |
| res_verify_err | output | 1 | Verify read mismatched (valid with done) |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Enables the data driver |
| fl_dq_in | input | 8 | Data read from the flash |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |

## Verification
A fault in the write-phase counters or the command index shows up on the flash pins during the first request. It appears as a pulse of the wrong length, a setup or hold window that is too short, or a write to the wrong address or with the wrong data. Each of these is caught at the write pulse where it occurs. A fault in the poll state, such as a stale previous bit 6, a wrong reference bit 7 or an off-by-one in the read budget, changes the number of status reads the device model sees before `done`. It can also change the result flags, so it becomes visible at the end of that same request. The device model sets busy lengths from zero to beyond the budget, both polarities of the toggle phase and corrupted verify bytes, so that the completion read falls on the first, the last and the over-budget read.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WSET  = 3'd1,
        ST_WLOW  = 3'd2,
        ST_WHOLD = 3'd3,
        ST_RD    = 3'd4,
        ST_RGAP  = 3'd5,
        ST_FIN   = 3'd6
    } fbp_state_e;

    localparam logic POLL_DATA   = 1'b0;
    localparam logic POLL_TOGGLE = 1'b1;

    // Nanoseconds to clock cycles, rounded up, never below one cycle.
    function automatic int fbp_ns2cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int fbp_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fbp_poll_eval.sv
module fbp_poll_eval (
    input  logic       mode,
    input  logic       verify,
    input  logic       have_prev,
    input  logic       prev6,
    input  logic [7:0] sample,
    input  logic [7:0] ref_data,
    output logic       complete,
    output logic       mismatch
);
    import fbp_pkg::*;

    always_comb begin
        complete = 1'b0;
        if (!verify) begin
            if (mode == POLL_TOGGLE) begin
                complete = have_prev && (sample[6] == prev6);
            end else begin
                complete = (sample[7] == ref_data[7]);
            end
        end
        mismatch = (sample != ref_data);
    end

endmodule

// File: rtl/fbp_bus_drv.sv
module fbp_bus_drv
    import fbp_pkg::*;
#(
    parameter int              AW      = 19,
    parameter logic [AW-1:0]   UNLK_A0 = 'h555,
    parameter logic [7:0]      UNLK_D0 = 8'hAA,
    parameter logic [AW-1:0]   UNLK_A1 = 'h2AA,
    parameter logic [7:0]      UNLK_D1 = 8'h55,
    parameter logic [AW-1:0]   CMD_A   = 'h555,
    parameter logic [7:0]      CMD_D   = 8'hA0
) (
    input  fbp_state_e      st,
    input  logic [1:0]      widx,
    input  logic [AW-1:0]   tgt_addr,
    input  logic [7:0]      tgt_data,
    output logic [AW-1:0]   fl_addr,
    output logic [7:0]      fl_dq_out,
    output logic            fl_dq_oe,
    output logic            fl_ce_n,
    output logic            fl_oe_n,
    output logic            fl_we_n
);
    localparam int NCMD = 3;

    logic [AW-1:0] slot_a [NCMD+1];
    logic [7:0]    slot_d [NCMD+1];
    logic          in_write;

    // Fixed command slots come from parameters; the last slot is the target byte.
    for (genvar g = 0; g < NCMD; g++) begin : g_cmd
        localparam logic [AW-1:0] SA = (g == 0) ? UNLK_A0 : (g == 1) ? UNLK_A1 : CMD_A;
        localparam logic [7:0]    SD = (g == 0) ? UNLK_D0 : (g == 1) ? UNLK_D1 : CMD_D;
        assign slot_a[g] = SA;
        assign slot_d[g] = SD;
    end
    assign slot_a[NCMD] = tgt_addr;
    assign slot_d[NCMD] = tgt_data;

    always_comb begin
        in_write  = (st == ST_WSET) || (st == ST_WLOW) || (st == ST_WHOLD);
        fl_addr   = in_write ? slot_a[widx] : tgt_addr;
        fl_dq_out = slot_d[widx];
        fl_dq_oe  = in_write;
        fl_ce_n   = !(in_write || (st == ST_RD));
        fl_oe_n   = (st != ST_RD);
        fl_we_n   = (st != ST_WLOW);
    end

endmodule

// File: rtl/fbp_seq.sv
module fbp_seq
    import fbp_pkg::*;
#(
    parameter int AW         = 19,
    parameter int SET_CYC    = 2,
    parameter int WP_CYC     = 2,
    parameter int HOLD_CYC   = 3,
    parameter int RD_CYC     = 6,
    parameter int GAP_CYC    = 2,
    parameter int POLL_LIMIT = 500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  logic [7:0]      req_data,
    input  logic            req_mode,
    input  logic [7:0]      rd_sample,
    input  logic            ev_complete,
    input  logic            ev_mismatch,
    output fbp_state_e      st_o,
    output logic [1:0]      widx_o,
    output logic [AW-1:0]   addr_o,
    output logic [7:0]      data_o,
    output logic            mode_o,
    output logic            verify_o,
    output logic            have_prev_o,
    output logic            prev6_o,
    output logic            res_to_o,
    output logic            res_err_o
);
    localparam int MAXC = fbp_max(fbp_max(fbp_max(SET_CYC, WP_CYC), fbp_max(HOLD_CYC, RD_CYC)), GAP_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    localparam int PW   = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        fbp_state_e      st;
        logic [CW-1:0]   cnt;
        logic [1:0]      widx;
        logic [AW-1:0]   addr;
        logic [7:0]      data;
        logic            mode;
        logic            verify;
        logic            have_prev;
        logic            prev6;
        logic [PW-1:0]   polls;
        logic            res_to;
        logic            res_err;
    } seq_t;

    seq_t ctl_q, ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st        = ST_WSET;
                    ctl_d.cnt       = '0;
                    ctl_d.widx      = '0;
                    ctl_d.addr      = req_addr;
                    ctl_d.data      = req_data;
                    ctl_d.mode      = req_mode;
                    ctl_d.verify    = 1'b0;
                    ctl_d.have_prev = 1'b0;
                    ctl_d.prev6     = 1'b0;
                    ctl_d.polls     = '0;
                    ctl_d.res_to    = 1'b0;
                    ctl_d.res_err   = 1'b0;
                end
            end
            ST_WSET: begin
                if (ctl_q.cnt == CW'(SET_CYC - 1)) begin
                    ctl_d.st  = ST_WLOW;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_WLOW: begin
                if (ctl_q.cnt == CW'(WP_CYC - 1)) begin
                    ctl_d.st  = ST_WHOLD;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_WHOLD: begin
                if (ctl_q.cnt == CW'(HOLD_CYC - 1)) begin
                    ctl_d.cnt = '0;
                    if (ctl_q.widx == 2'd3) begin
                        ctl_d.st = ST_RD;
                    end else begin
                        ctl_d.widx = ctl_q.widx + 1'b1;
                        ctl_d.st   = ST_WSET;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_RD: begin
                if (ctl_q.cnt == CW'(RD_CYC - 1)) begin
                    ctl_d.cnt       = '0;
                    ctl_d.have_prev = 1'b1;
                    ctl_d.prev6     = rd_sample[6];
                    if (ctl_q.verify) begin
                        ctl_d.res_err = ev_mismatch;
                        ctl_d.st      = ST_FIN;
                    end else if (ev_complete) begin
                        if (ctl_q.mode == POLL_TOGGLE) begin
                            ctl_d.st = ST_FIN;
                        end else begin
                            ctl_d.verify = 1'b1;
                            ctl_d.st     = ST_RGAP;
                        end
                    end else if (ctl_q.polls == PW'(POLL_LIMIT - 1)) begin
                        ctl_d.res_to = 1'b1;
                        ctl_d.st     = ST_FIN;
                    end else begin
                        ctl_d.polls = ctl_q.polls + 1'b1;
                        ctl_d.st    = ST_RGAP;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_RGAP: begin
                if (ctl_q.cnt == CW'(GAP_CYC - 1)) begin
                    ctl_d.st  = ST_RD;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_FIN:  ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign st_o        = ctl_q.st;
    assign widx_o      = ctl_q.widx;
    assign addr_o      = ctl_q.addr;
    assign data_o      = ctl_q.data;
    assign mode_o      = ctl_q.mode;
    assign verify_o    = ctl_q.verify;
    assign have_prev_o = ctl_q.have_prev;
    assign prev6_o     = ctl_q.prev6;
    assign res_to_o    = ctl_q.res_to;
    assign res_err_o   = ctl_q.res_err;

endmodule

// File: rtl/flash_byte_prog.sv
module flash_byte_prog
    import fbp_pkg::*;
#(
    parameter int              AW          = 19,
    parameter int              CLK_NS      = 10,
    parameter int              T_WP_NS     = 20,
    parameter int              T_WPH_NS    = 20,
    parameter int              T_AS_NS     = 0,
    parameter int              T_AH_NS     = 25,
    parameter int              T_DS_NS     = 20,
    parameter int              T_RD_NS     = 55,
    parameter int              T_RGAP_NS   = 20,
    parameter int              PROG_MAX_NS = 40000,
    parameter logic [AW-1:0]   UNLK_A0     = 'h555,
    parameter logic [7:0]      UNLK_D0     = 8'hAA,
    parameter logic [AW-1:0]   UNLK_A1     = 'h2AA,
    parameter logic [7:0]      UNLK_D1     = 8'h55,
    parameter logic [AW-1:0]   CMD_A       = 'h555,
    parameter logic [7:0]      CMD_D       = 8'hA0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_addr,
    input  logic [7:0]      req_data,
    input  logic            req_mode,
    output logic            done,
    output logic            res_timeout,
    output logic            res_verify_err,
    output logic [AW-1:0]   fl_addr,
    output logic [7:0]      fl_dq_out,
    output logic            fl_dq_oe,
    input  logic [7:0]      fl_dq_in,
    output logic            fl_ce_n,
    output logic            fl_oe_n,
    output logic            fl_we_n
);
    localparam int SET_CYC    = fbp_max(fbp_ns2cyc(T_DS_NS, CLK_NS), fbp_ns2cyc(T_AS_NS, CLK_NS));
    localparam int WP_CYC     = fbp_ns2cyc(T_WP_NS, CLK_NS);
    localparam int HOLD_CYC   = fbp_max(fbp_ns2cyc(T_AH_NS, CLK_NS), fbp_ns2cyc(T_WPH_NS, CLK_NS));
    localparam int RD_CYC     = fbp_ns2cyc(T_RD_NS, CLK_NS);
    localparam int GAP_CYC    = fbp_ns2cyc(T_RGAP_NS, CLK_NS);
    localparam int POLL_LIMIT = fbp_max(2, fbp_ns2cyc(PROG_MAX_NS, (RD_CYC + GAP_CYC) * CLK_NS));

    fbp_state_e    st;
    logic [1:0]    widx;
    logic [AW-1:0] tgt_addr;
    logic [7:0]    tgt_data;
    logic          mode, verify, have_prev, prev6;
    logic          ev_complete, ev_mismatch;

    fbp_seq #(
        .AW(AW), .SET_CYC(SET_CYC), .WP_CYC(WP_CYC), .HOLD_CYC(HOLD_CYC),
        .RD_CYC(RD_CYC), .GAP_CYC(GAP_CYC), .POLL_LIMIT(POLL_LIMIT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_data    (req_data),
        .req_mode    (req_mode),
        .rd_sample   (fl_dq_in),
        .ev_complete (ev_complete),
        .ev_mismatch (ev_mismatch),
        .st_o        (st),
        .widx_o      (widx),
        .addr_o      (tgt_addr),
        .data_o      (tgt_data),
        .mode_o      (mode),
        .verify_o    (verify),
        .have_prev_o (have_prev),
        .prev6_o     (prev6),
        .res_to_o    (res_timeout),
        .res_err_o   (res_verify_err)
    );

    fbp_poll_eval u_eval (
        .mode      (mode),
        .verify    (verify),
        .have_prev (have_prev),
        .prev6     (prev6),
        .sample    (fl_dq_in),
        .ref_data  (tgt_data),
        .complete  (ev_complete),
        .mismatch  (ev_mismatch)
    );

    fbp_bus_drv #(
        .AW(AW), .UNLK_A0(UNLK_A0), .UNLK_D0(UNLK_D0), .UNLK_A1(UNLK_A1),
        .UNLK_D1(UNLK_D1), .CMD_A(CMD_A), .CMD_D(CMD_D)
    ) u_bus (
        .st        (st),
        .widx      (widx),
        .tgt_addr  (tgt_addr),
        .tgt_data  (tgt_data),
        .fl_addr   (fl_addr),
        .fl_dq_out (fl_dq_out),
        .fl_dq_oe  (fl_dq_oe),
        .fl_ce_n   (fl_ce_n),
        .fl_oe_n   (fl_oe_n),
        .fl_we_n   (fl_we_n)
    );

    assign req_ready = (st == ST_IDLE);
    assign done      = (st == ST_FIN);

endmodule

// File: rtl/flash_byte_prog_chk.sv
module flash_byte_prog_chk #(
    parameter int AW     = 19,
    parameter int WP_CYC = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            done,
    input logic            res_timeout,
    input logic            res_verify_err,
    input logic [AW-1:0]   fl_addr,
    input logic [7:0]      fl_dq_out,
    input logic            fl_dq_oe,
    input logic            fl_ce_n,
    input logic            fl_oe_n,
    input logic            fl_we_n
);
    logic [7:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (!fl_we_n) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end else begin
            low_cnt_q <= '0;
        end
    end

    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (fl_oe_n && !fl_ce_n)); // R4

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> !fl_dq_oe); // R5

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (low_cnt_q == 8'(WP_CYC))); // R3

    AST_STABLE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out))); // R3

    AST_HOLD_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_out) && fl_dq_oe)); // R3

    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe)); // R11

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready)); // R10

    AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready); // R1

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(res_timeout && res_verify_err)); // R9

endmodule

bind flash_byte_prog flash_byte_prog_chk #(.AW(AW), .WP_CYC(WP_CYC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_ready      (req_ready),
    .done           (done),
    .res_timeout    (res_timeout),
    .res_verify_err (res_verify_err),
    .fl_addr        (fl_addr),
    .fl_dq_out      (fl_dq_out),
    .fl_dq_oe       (fl_dq_oe),
    .fl_ce_n        (fl_ce_n),
    .fl_oe_n        (fl_oe_n),
    .fl_we_n        (fl_we_n)
);

// File: tb/flash_byte_prog_tb.sv
module flash_byte_prog_tb;
    localparam int AW       = 19;
    // Cycle counts from the requirements at a 10 ns clock with default timings.
    localparam int SET_C    = 2;   // ceil(20/10)
    localparam int WP_C     = 2;   // ceil(20/10)
    localparam int HOLD_C   = 3;   // max(ceil(25/10), ceil(20/10))
    localparam int RD_C     = 6;   // ceil(55/10)
    localparam int GAP_C    = 2;   // ceil(20/10)
    localparam int PMAX_NS  = 2000;
    localparam int LIMIT    = (PMAX_NS + (RD_C + GAP_C) * 10 - 1) / ((RD_C + GAP_C) * 10); // 25

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic            req_valid, req_ready, req_mode;
    logic [AW-1:0]   req_addr;
    logic [7:0]      req_data;
    logic            done, res_timeout, res_verify_err;
    logic [AW-1:0]   fl_addr;
    logic [7:0]      fl_dq_out, fl_dq_in;
    logic            fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

    flash_byte_prog #(.AW(AW), .PROG_MAX_NS(PMAX_NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_mode(req_mode),
        .done(done), .res_timeout(res_timeout), .res_verify_err(res_verify_err),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    int n_checks = 0;
    int n_errors = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Device model: the first m_busy reads show busy status, later reads the stored byte.
    logic [7:0]    m_data = 8'h00;
    logic [7:0]    m_mask = 8'h00;
    logic [AW-1:0] m_addr = '0;
    int            m_busy = 0;
    int            rd_base = 0;
    int            rd_done = 0;

    function automatic logic [7:0] model_byte(input int i);
        if (i < m_busy) return {~m_data[7], (~m_data[6]) ^ (i % 2 == 1), 6'b101010};
        return m_data ^ m_mask;
    endfunction

    assign fl_dq_in = model_byte(rd_done - rd_base);

    // Bus monitor, sampling away from the active edge.
    int            wr_total = 0;
    logic [AW-1:0] wr_a [256];
    logic [7:0]    wr_d [256];
    int            viol = 0;
    int            stab = 0, lowc = 0, holdc = 0, gapc = 0, oelow = 0;
    bit            hold_on = 0, gap_on = 0;
    logic          p_we = 1'b1, p_oe = 1'b1, p_doe = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [7:0]    p_dout = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!fl_we_n && (!fl_oe_n || fl_ce_n)) viol++;   // R4
            if (!fl_oe_n && fl_dq_oe) viol++;                // R5
            if (fl_dq_oe && !fl_ce_n)
                stab = (p_doe && fl_addr == p_addr && fl_dq_out == p_dout) ? stab + 1 : 1;
            else
                stab = 0;
            if (!fl_we_n && p_we) begin
                if (stab < SET_C + 1) viol++;                // R3 setup
                if (hold_on) begin
                    if (holdc < HOLD_C) viol++;
                    hold_on = 0;
                end
                if (gap_on && gapc < HOLD_C + SET_C) viol++;
                wr_a[wr_total % 256] = fl_addr;
                wr_d[wr_total % 256] = fl_dq_out;
                wr_total++;
                lowc = 1;
            end else if (!fl_we_n) begin
                lowc++;
            end
            if (fl_we_n && !p_we) begin
                if (lowc != WP_C) viol++;                    // R3 pulse
                if (fl_addr != p_addr || fl_dq_out != p_dout) viol++;
                hold_on = 1; holdc = 1; gap_on = 1; gapc = 1;
            end else if (fl_we_n) begin
                if (hold_on) begin
                    if (fl_dq_oe && !fl_ce_n && fl_addr == p_addr && fl_dq_out == p_dout) holdc++;
                    else begin
                        if (holdc < HOLD_C) viol++;          // R3 hold
                        hold_on = 0;
                    end
                end
                if (gap_on) gapc++;
            end
            if (fl_ce_n) gap_on = 0;
            if (!fl_oe_n && p_oe) begin
                oelow = 1;
                if (fl_addr != m_addr) viol++;               // R5 address
            end else if (!fl_oe_n) begin
                oelow++;
            end
            if (fl_oe_n && !p_oe) begin
                if (oelow != RD_C) viol++;                   // R5 length
                rd_done++;
            end
        end
        p_we = fl_we_n; p_oe = fl_oe_n; p_doe = fl_dq_oe;
        p_addr = fl_addr; p_dout = fl_dq_out;
    end

    // Expected outcome computed from the requirements.
    function automatic void expect_res(input bit mode, input logic [7:0] d, input int busy,
                                       input logic [7:0] mask, output bit to, output bit err,
                                       output int reads);
        logic prev;
        logic [7:0] v;
        prev = 1'b0;
        for (int i = 0; i < LIMIT; i++) begin
            if (i < busy) v = {~d[7], (~d[6]) ^ (i % 2 == 1), 6'b101010};
            else          v = d ^ mask;
            if (!mode && v[7] == d[7]) begin
                to = 0; err = (mask != 8'h00); reads = i + 2; return;
            end
            if (mode && i > 0 && v[6] == prev) begin
                to = 0; err = 0; reads = i + 1; return;
            end
            prev = v[6];
        end
        to = 1; err = 0; reads = LIMIT;
    endfunction

    task automatic run_txn(input bit mode, input logic [AW-1:0] a, input logic [7:0] d,
                           input int busy, input logic [7:0] mask);
        bit e_to, e_err, got_done, early_ready, f_to, f_err, idle_ok;
        int e_reads, w0, v0, cyc;
        string rq;
        expect_res(mode, d, busy, mask, e_to, e_err, e_reads);
        @(negedge clk);
        m_data = d; m_busy = busy; m_mask = mask; m_addr = a;
        rd_base = rd_done; w0 = wr_total; v0 = viol;
        req_valid = 1'b1; req_addr = a; req_data = d; req_mode = mode;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = ~a; req_data = ~d; req_mode = ~mode;
        chk(req_ready == 1'b0, "R1", "ready after accept", req_ready, 0);
        got_done = 0; early_ready = 0; cyc = 0;
        f_to = 0; f_err = 0; idle_ok = 0;
        while (!got_done && cyc < 5000) begin
            if (done) begin
                got_done = 1;
                f_to = res_timeout; f_err = res_verify_err;
                idle_ok = fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe;
            end else begin
                if (req_ready) early_ready = 1;
                @(negedge clk);
                cyc++;
            end
        end
        chk(got_done, "R10", "done seen", got_done, 1);
        chk(!early_ready, "R1", "ready while busy", early_ready, 0);
        chk(f_to == e_to, "R9", "timeout flag", f_to, e_to);
        rq = mode ? "R8" : "R7";
        chk(f_err == e_err, rq, "verify error flag", f_err, e_err);
        chk(idle_ok, "R9", "bus idle at done", idle_ok, 1);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done width", done, 0);
        chk(req_ready == 1'b1, "R10", "ready after done", req_ready, 1);
        rq = e_to ? "R9" : (mode ? "R8" : "R6");
        chk((rd_done - rd_base) == e_reads, rq, "status read count", rd_done - rd_base, e_reads);
        chk((wr_total - w0) == 4, "R2", "write count", wr_total - w0, 4);
        if (wr_total - w0 == 4) begin
            chk(wr_a[w0 % 256] == 19'h555 && wr_d[w0 % 256] == 8'hAA, "R2", "first write",
                int'(wr_d[w0 % 256]), 8'hAA);
            chk(wr_a[(w0 + 1) % 256] == 19'h2AA && wr_d[(w0 + 1) % 256] == 8'h55, "R2", "second write",
                int'(wr_d[(w0 + 1) % 256]), 8'h55);
            chk(wr_a[(w0 + 2) % 256] == 19'h555 && wr_d[(w0 + 2) % 256] == 8'hA0, "R2", "command write",
                int'(wr_d[(w0 + 2) % 256]), 8'hA0);
            chk(wr_a[(w0 + 3) % 256] == a && wr_d[(w0 + 3) % 256] == d, "R2", "byte write",
                int'(wr_d[(w0 + 3) % 256]), int'(d));
        end
        chk(viol == v0, "R3", "setup/pulse/hold/read timing violations", viol - v0, 0);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0; req_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0, "R11", "ready/done in reset", {req_ready, done}, 2);
        chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R11", "bus idle in reset",
            {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 14);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && fl_ce_n && fl_we_n, "R11", "idle after reset", req_ready, 1);

        // Directed corners.
        run_txn(1'b0, 19'h01234, 8'h5A, 0, 8'h00);          // R6 immediate completion
        run_txn(1'b0, 19'h7FFFF, 8'hC3, 7, 8'h00);          // R6
        run_txn(1'b0, 19'h00010, 8'h81, 3, 8'h05);          // R7 mismatch on verify
        run_txn(1'b1, 19'h00200, 8'h40, 0, 8'h00);          // R8 stable from start
        run_txn(1'b1, 19'h00201, 8'h00, 4, 8'h00);          // R8 even busy length
        run_txn(1'b1, 19'h00202, 8'h7F, 5, 8'h00);          // R8 odd busy length
        run_txn(1'b0, 19'h03000, 8'h11, LIMIT - 1, 8'h00);  // R9 completion on last read
        run_txn(1'b0, 19'h03001, 8'h22, LIMIT + 4, 8'h00);  // R9 timeout, data poll
        run_txn(1'b1, 19'h03002, 8'h33, LIMIT + 4, 8'h00);  // R9 timeout, toggle

        // Constrained random mix.
        for (int k = 0; k < 24; k++) begin
            bit          md;
            logic [AW-1:0] ad;
            logic [7:0]  dt, mk;
            int          bz;
            md = 1'($urandom_range(0, 1));
            ad = AW'($urandom);
            dt = 8'($urandom);
            bz = $urandom_range(0, 12);
            mk = ($urandom_range(0, 3) == 0) ? {2'b00, 6'($urandom_range(1, 63))} : 8'h00;
            run_txn(md, ad, dt, bz, mk);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule